// File: doc/BRIEF.md
# Addressed Asynchronous Serial Receiver

This block receives asynchronous serial frames from an oversampled line. In addressed mode each frame carries one extra flag bit after the data bits. Receivers on a shared line use that bit to tell address frames (flag 1) from data frames (flag 0). Software can arm a wait-for-address state. While it is armed, data frames pass through the shift logic but leave no trace: nothing is copied, no flag is raised and no interrupt is requested. The first address frame clears the armed state in hardware, and normal reception resumes with that frame.

Software controls the block through a five-bit control register and reads a four-bit status register. Writing 0 to a status flag clears it. Reading the data register, signalled by a strobe, clears the ready flag. A `tick` input, pulsing at the oversampling rate, paces all sampling. Baud generation, transmission and clocked synchronous operation are outside this block.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, the control register, the status register and the data register read 0, and both interrupt outputs are 0.
- R2: Control bit positions are 0 enable, 1 addressed mode, 2 wait-for-address, 3 synchronous select, 4 interrupt enable. Status bit positions are 0 ready, 1 framing error, 2 overrun, 3 last flag bit. A status write clears each of bits 0 to 2 where the written bit is 0 and leaves it where the written bit is 1. Bit 3 cannot be written. A pulse on `rdr_re` clears ready.
- R3: A frame is received only while enable is 1 and synchronous select is 0. A start is detected when the line reads 0 on a tick, and it must still read 0 half a bit later. In every other case, line activity changes no register.
- R4: A frame is a 0 start bit, then DATA_BITS data bits LSB first, then the flag bit (present only when addressed mode is 1 at the start bit), then the stop bit. Each bit lasts OVS ticks and is sampled at its middle. After a stop bit sampled as 0, the receiver waits for the line to return to 1 before it looks for a new start.
- R5: A frame that completes while ready is 0 loads the data register and sets ready. If its stop bit was 0, it also sets the framing-error flag.
- R6: A frame that completes while ready is 1 sets the overrun flag and leaves the data register unchanged. A stop bit of 0 still sets the framing-error flag.
- R7: Every completed frame that carries a flag bit copies that bit into status bit 3, including discarded frames. Frames without a flag bit leave status bit 3 unchanged.
- R8: Clearing enable abandons any frame in progress. The status flags and the data register keep their values.
- R9: While wait-for-address is effective, a frame whose flag bit is 0 changes neither the data register nor status bits 0 to 2. Wait-for-address is effective when control bits 2 and 1 are 1 and bit 3 is 0.
- R10: While wait-for-address is effective, a frame whose flag bit is 1 clears control bit 2, even against a control write in the same cycle, and sets status bit 3. That frame is then received as in R5 and R6.
- R11: When addressed mode is 0, control bit 2 has no effect: frames are received normally and the bit keeps its written value.
- R12: `rxi_req` is 1 exactly when ready and the interrupt enable are both 1. `eri_req` is 1 exactly when the interrupt enable is 1 and the framing-error or overrun flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| rx_in | input | 1 | Serial line, asynchronous to clk |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 5 | Control write value |
| stat_we | input | 1 | Write strobe for the status register (0 clears a flag) |
| stat_wdata | input | 4 | Status write value |
| rdr_re | input | 1 | Data register read strobe; clears ready |
| ctrl_q | output | 5 | Control register |
| stat_q | output | 4 | Status register |
| rdr_q | output | DATA_BITS | Received data register |
| rxi_req | output | 1 | Receive interrupt request |
| eri_req | output | 1 | Error interrupt request |

## Verification
The bench builds the block with DATA_BITS = 8 and OVS = 8, and pulses `tick` every second clock, so one bit lasts 16 clocks. This keeps each frame short, and the run can cover many random frames in both frame lengths, with and without wait-for-address armed, within a few thousand cycles per scenario. The start-confirm delay at half a bit is four ticks at this setting. The synchronizer delay therefore moves the sampling point by a visible but safe fraction of a bit, which exercises the tolerance of the mid-bit sampling.

// File: rtl/mpr_pkg.sv
// Shared types for the addressed serial receiver.
// Assumes: control and status layouts listed in the brief, bit 0 at the right.
package mpr_pkg;
    localparam int CTRL_W = 5;
    localparam int STAT_W = 4;

    typedef struct packed {
        logic rx_ie;
        logic sync_sel;
        logic addr_wait;
        logic mp_mode;
        logic rx_en;
    } mpr_ctrl_t;

    typedef struct packed {
        logic mpbr;
        logic ovr;
        logic ferr;
        logic ready;
    } mpr_stat_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_BITS,
        FR_BREAK
    } mpr_fr_state_e;
endpackage

// File: rtl/mpr_sync.sv
// Multi-stage synchronizer for the serial line.
// Assumes: STAGES >= 2. Resets to the idle level 1.
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    // Shift the asynchronous line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/mpr_frame_rx.sv
// Frame engine: detects the start bit, samples each bit at its middle and
// reports a completed frame with a one-cycle done pulse.
// Assumes: rx_s is already synchronized, tick pulses OVS times per bit,
// OVS is even and at least 4. The flag-bit format is fixed at the start bit.
module mpr_frame_rx import mpr_pkg::*; #(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_s,
    input  logic                 run,
    input  logic                 with_mpb,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 mpb,
    output logic                 has_mpb,
    output logic                 stop_ok
);
    localparam int CW   = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IW   = $clog2(DATA_BITS + 3);
    localparam int HALF = OVS / 2;

    mpr_fr_state_e        state_q;
    logic [CW-1:0]        cnt_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] data_q;
    logic                 mpb_q;
    logic                 fmt_q;
    logic [IW-1:0]        last_idx;
    logic                 bit_mid;
    logic                 at_stop;

    // The stop bit comes after the data bits and, if present, the flag bit.
    assign last_idx = fmt_q ? IW'(DATA_BITS + 1) : IW'(DATA_BITS);
    assign bit_mid  = (state_q == FR_BITS) && tick && (cnt_q == CW'(OVS - 1));
    assign at_stop  = bit_mid && (idx_q == last_idx);
    assign done     = at_stop && run;
    assign data     = data_q;
    assign mpb      = mpb_q;
    assign has_mpb  = fmt_q;
    assign stop_ok  = rx_s;

    // Sequence start detection, bit counting and the wait after a break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            fmt_q   <= 1'b0;
        end else if (!run) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                FR_IDLE: begin
                    if (tick && !rx_s) begin
                        state_q <= FR_START;
                        cnt_q   <= '0;
                        fmt_q   <= with_mpb;
                    end
                end
                FR_START: begin
                    if (tick) begin
                        if (cnt_q == CW'(HALF - 1)) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            state_q <= rx_s ? FR_IDLE : FR_BITS;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                FR_BITS: begin
                    if (tick) begin
                        if (cnt_q == CW'(OVS - 1)) begin
                            cnt_q <= '0;
                            if (idx_q == last_idx) state_q <= rx_s ? FR_IDLE : FR_BREAK;
                            else                   idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (rx_s) state_q <= FR_IDLE;
                end
            endcase
        end
    end

    // Capture data bits and the flag bit at their mid-bit points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mpb_q  <= 1'b0;
        end else if (bit_mid && run) begin
            for (int i = 0; i < DATA_BITS; i++) begin
                if (idx_q == IW'(i)) data_q[i] <= rx_s;
            end
            if (fmt_q && (idx_q == IW'(DATA_BITS))) mpb_q <= rx_s;
        end
    end
endmodule

// File: rtl/mpr_regs.sv
// Control, status and data registers, with the wait-for-address filter.
// Assumes: frame results are valid only in the cycle done is 1. Flags set
// by hardware win over software clears in the same cycle. The hardware
// clear of the wait bit wins over a control write.
module mpr_regs import mpr_pkg::*; #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  mpr_ctrl_t            ctrl_wdata,
    input  logic                 stat_we,
    input  mpr_stat_t            stat_wdata,
    input  logic                 rdr_re,
    input  logic                 frm_done,
    input  logic [DATA_BITS-1:0] frm_data,
    input  logic                 frm_mpb,
    input  logic                 frm_has_mpb,
    input  logic                 frm_stop_ok,
    output mpr_ctrl_t            ctrl_q,
    output mpr_stat_t            stat_q,
    output logic [DATA_BITS-1:0] rdr_q
);
    mpr_ctrl_t ctrl_d;
    mpr_stat_t stat_d;
    logic      wait_eff;
    logic      discard;
    logic      wake;
    logic      accept;

    // Decide what the completed frame is allowed to change.
    always_comb begin
        wait_eff = ctrl_q.addr_wait && ctrl_q.mp_mode && !ctrl_q.sync_sel;
        discard  = frm_done && frm_has_mpb && !frm_mpb && wait_eff;
        wake     = frm_done && frm_has_mpb && frm_mpb && wait_eff;
        accept   = frm_done && !discard;
    end

    // Next control value: software write, then the hardware wait clear.
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) ctrl_d = ctrl_wdata;
        if (wake)    ctrl_d.addr_wait = 1'b0;
    end

    // Next status value: software clears first, hardware sets last.
    always_comb begin
        stat_d = stat_q;
        if (stat_we) begin
            stat_d.ready = stat_q.ready & stat_wdata.ready;
            stat_d.ferr  = stat_q.ferr  & stat_wdata.ferr;
            stat_d.ovr   = stat_q.ovr   & stat_wdata.ovr;
        end
        if (rdr_re) stat_d.ready = 1'b0;
        if (frm_done && frm_has_mpb) stat_d.mpbr = frm_mpb;
        if (accept) begin
            if (stat_q.ready) stat_d.ovr   = 1'b1;
            else              stat_d.ready = 1'b1;
            if (!frm_stop_ok) stat_d.ferr = 1'b1;
        end
    end

    // Register the control and status values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
        end
    end

    // Load received data only when the previous byte has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rdr_q <= '0;
        else if (accept && !stat_q.ready) rdr_q <= frm_data;
    end
endmodule

// File: rtl/mp_uart_rx.sv
// Top of the addressed serial receiver: synchronizer, frame engine,
// register file and interrupt outputs.
// Assumes: tick comes from an external baud divider at OVS per bit.
module mp_uart_rx import mpr_pkg::*; #(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_in,
    input  logic                 ctrl_we,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    input  logic                 stat_we,
    input  logic [STAT_W-1:0]    stat_wdata,
    input  logic                 rdr_re,
    output logic [CTRL_W-1:0]    ctrl_q,
    output logic [STAT_W-1:0]    stat_q,
    output logic [DATA_BITS-1:0] rdr_q,
    output logic                 rxi_req,
    output logic                 eri_req
);
    logic                 rx_s;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_mpb;
    logic                 frm_has_mpb;
    logic                 frm_stop_ok;
    mpr_ctrl_t            ctrl_s;
    mpr_stat_t            stat_s;
    logic                 run;

    assign run = ctrl_s.rx_en && !ctrl_s.sync_sel;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
    );

    mpr_frame_rx #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .run(run),
        .with_mpb(ctrl_s.mp_mode), .done(frm_done), .data(frm_data),
        .mpb(frm_mpb), .has_mpb(frm_has_mpb), .stop_ok(frm_stop_ok)
    );

    mpr_regs #(.DATA_BITS(DATA_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(mpr_ctrl_t'(ctrl_wdata)),
        .stat_we(stat_we), .stat_wdata(mpr_stat_t'(stat_wdata)),
        .rdr_re(rdr_re), .frm_done(frm_done), .frm_data(frm_data),
        .frm_mpb(frm_mpb), .frm_has_mpb(frm_has_mpb), .frm_stop_ok(frm_stop_ok),
        .ctrl_q(ctrl_s), .stat_q(stat_s), .rdr_q(rdr_q)
    );

    assign ctrl_q = ctrl_s;
    assign stat_q = stat_s;

    // Interrupt requests follow the flags gated by the shared enable.
    always_comb begin
        rxi_req = stat_s.ready && ctrl_s.rx_ie;
        eri_req = (stat_s.ferr || stat_s.ovr) && ctrl_s.rx_ie;
    end
endmodule

// File: rtl/mpr_checker.sv
// Temporal checks for the addressed serial receiver, bound to its top.
module mpr_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctrl_we,
    input logic                 stat_we,
    input logic                 rdr_re,
    input logic [4:0]           ctrl_q,
    input logic [3:0]           stat_q,
    input logic [DATA_BITS-1:0] rdr_q,
    input logic                 rxi_req,
    input logic                 eri_req,
    input logic                 frm_done,
    input logic                 frm_mpb,
    input logic                 frm_has_mpb
);
    a_r2_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rdr_re && !frm_done) |=> !stat_q[0]);

    a_r3_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[0]) |-> ($past(ctrl_q[0]) && !$past(ctrl_q[3])));

    a_r8_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[0] && !stat_we && !rdr_re) |=> ($stable(stat_q) && $stable(rdr_q)));

    a_r9_discard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_has_mpb && !frm_mpb && ctrl_q[2] && ctrl_q[1] && !ctrl_q[3]
         && !stat_we && !rdr_re) |=> ($stable(stat_q[2:0]) && $stable(rdr_q)));

    a_r10_wake_clears_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_has_mpb && frm_mpb && ctrl_q[2] && ctrl_q[1] && !ctrl_q[3])
        |=> (!ctrl_q[2] && stat_q[3]));

    a_r6_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && stat_q[0] && !(frm_has_mpb && !frm_mpb && ctrl_q[2] && !ctrl_q[3]))
        |=> (stat_q[2] && $stable(rdr_q)));

    a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (rxi_req || eri_req) |-> ctrl_q[4]);
endmodule

bind mp_uart_rx mpr_checker #(.DATA_BITS(DATA_BITS)) u_mpr_checker (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .stat_we(stat_we),
    .rdr_re(rdr_re), .ctrl_q(ctrl_q), .stat_q(stat_q), .rdr_q(rdr_q),
    .rxi_req(rxi_req), .eri_req(eri_req), .frm_done(frm_done),
    .frm_mpb(frm_mpb), .frm_has_mpb(frm_has_mpb)
);

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
    localparam int DW      = 8;
    localparam int OVS     = 8;
    localparam int BIT_CLK = OVS * 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick;
    logic          tdiv;
    logic          rx_in = 1'b1;
    logic          ctrl_we = 1'b0;
    logic [4:0]    ctrl_wdata = '0;
    logic          stat_we = 1'b0;
    logic [3:0]    stat_wdata = '0;
    logic          rdr_re = 1'b0;
    logic [4:0]    ctrl_q;
    logic [3:0]    stat_q;
    logic [DW-1:0] rdr_q;
    logic          rxi_req;
    logic          eri_req;

    int            n_checks = 0;
    int            n_errors = 0;
    logic [4:0]    e_ctrl = '0;
    logic [3:0]    e_stat = '0;
    logic [DW-1:0] e_rdr = '0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tdiv <= 1'b0;
        else        tdiv <= ~tdiv;
    end
    assign tick = tdiv;

    mp_uart_rx #(.DATA_BITS(DW), .OVS(OVS), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .rdr_re(rdr_re), .ctrl_q(ctrl_q),
        .stat_q(stat_q), .rdr_q(rdr_q), .rxi_req(rxi_req), .eri_req(eri_req)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "ctrl", {3'b0, ctrl_q}, {3'b0, e_ctrl});
        chk(tag, "stat", {4'b0, stat_q}, {4'b0, e_stat});
        chk(tag, "rdr", rdr_q, e_rdr);
        chk(tag, "rxi", {7'b0, rxi_req}, {7'b0, e_stat[0] & e_ctrl[4]});
        chk(tag, "eri", {7'b0, eri_req}, {7'b0, (e_stat[1] | e_stat[2]) & e_ctrl[4]});
    endtask

    task automatic ctrl_write(input logic [4:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
        e_ctrl = v;
    endtask

    task automatic stat_write(input logic [3:0] v);
        @(negedge clk); stat_we = 1'b1; stat_wdata = v;
        @(negedge clk); stat_we = 1'b0;
        e_stat[2:0] = e_stat[2:0] & v[2:0];
    endtask

    task automatic rdr_read();
        @(negedge clk); rdr_re = 1'b1;
        @(negedge clk); rdr_re = 1'b0;
        e_stat[0] = 1'b0;
    endtask

    task automatic drive_bit(input logic b);
        rx_in = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // Expected effect of one complete frame, from the requirements.
    task automatic model_frame(input logic [DW-1:0] d, input logic mb, input logic sb);
        logic with_mb, wait_eff;
        if (!e_ctrl[0] || e_ctrl[3]) return;
        with_mb  = e_ctrl[1];
        wait_eff = e_ctrl[2] & e_ctrl[1] & ~e_ctrl[3];
        if (with_mb) e_stat[3] = mb;
        if (wait_eff && !mb) return;
        if (wait_eff && mb) e_ctrl[2] = 1'b0;
        if (e_stat[0]) e_stat[2] = 1'b1;
        else begin e_rdr = d; e_stat[0] = 1'b1; end
        if (!sb) e_stat[1] = 1'b1;
    endtask

    task automatic send_frame(input logic [DW-1:0] d, input logic mb, input logic sb);
        logic with_mb;
        with_mb = e_ctrl[1];
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < DW; i++) drive_bit(d[i]);
        if (with_mb) drive_bit(mb);
        drive_bit(sb);
        drive_bit(1'b1);
        drive_bit(1'b1);
        model_frame(d, mb, sb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_all("R1");

        // R3: disabled receiver ignores a frame.
        send_frame(8'h5A, 1'b0, 1'b1);
        chk_all("R3");

        // R4/R5: plain 8-bit frame with the interrupt enabled.
        ctrl_write(5'b10001);
        send_frame(8'hA5, 1'b0, 1'b1);
        chk_all("R5");
        chk("R4", "data order", rdr_q, 8'hA5);

        // R6: second frame without a read.
        send_frame(8'h3C, 1'b0, 1'b1);
        chk_all("R6");

        // R2: status write clears, data read clears ready.
        stat_write(4'b1011);
        chk_all("R2");
        rdr_read();
        stat_write(4'b0000);
        chk_all("R2");

        // R5: bad stop sets the framing error, then break recovery (R4).
        send_frame(8'h81, 1'b0, 1'b0);
        chk_all("R5");
        rdr_read();
        stat_write(4'b0000);
        send_frame(8'h7E, 1'b0, 1'b1);
        chk_all("R4");
        rdr_read();

        // R9: armed wait, data frame discarded.
        ctrl_write(5'b10111);
        send_frame(8'h11, 1'b0, 1'b1);
        chk_all("R9");

        // R10: address frame wakes and is received.
        send_frame(8'h42, 1'b1, 1'b1);
        chk_all("R10");
        rdr_read();

        // R7: flag bit recorded outside the wait state.
        send_frame(8'h24, 1'b0, 1'b1);
        chk_all("R7");
        rdr_read();
        send_frame(8'h99, 1'b1, 1'b1);
        chk_all("R7");
        rdr_read();

        // R11: addressed mode off, wait bit written but ignored.
        ctrl_write(5'b10101);
        send_frame(8'hC3, 1'b1, 1'b1);
        chk_all("R11");
        rdr_read();
        ctrl_write(5'b11111);
        send_frame(8'h66, 1'b0, 1'b1);
        chk_all("R11");

        // R8: abandon a frame part way, flags and data hold.
        ctrl_write(5'b10001);
        send_frame(8'h0F, 1'b0, 1'b1);
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < 3; i++) drive_bit(1'b1);
        ctrl_write(5'b10000);
        for (int i = 0; i < 5; i++) drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b1);
        chk_all("R8");
        rdr_read();
        stat_write(4'b0000);
        ctrl_write(5'b10001);
        send_frame(8'hE7, 1'b0, 1'b1);
        chk_all("R8");
        rdr_read();

        // Random mix over all modes.
        for (int n = 0; n < 40; n++) begin
            logic [4:0] cv;
            if (($urandom % 4) == 0) begin
                cv = 5'($urandom);
                cv[0] = (($urandom % 8) != 0);
                cv[3] = (($urandom % 8) == 0);
                ctrl_write(cv);
            end
            send_frame(8'($urandom), (($urandom % 3) == 0), (($urandom % 8) != 0));
            chk_all("R12");
            case ($urandom % 3)
                0: rdr_read();
                1: stat_write(4'($urandom));
                default: ;
            endcase
            chk_all("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule